// File: doc/BRIEF.md
# Pipeline Stall and Flush Sequencer

This block sequences hazard control for an in-order pipeline of `STAGES` stages. It keeps a shadow of what each stage holds: an occupied bit, a register-write bit and an instruction tag. It advances that shadow every cycle. Stall requests arrive as "hold everything up to stage s", and the block turns them into one stall enable per stage. A stage that stops while its successor moves on leaves exactly one empty slot behind it.

Flushes come from two sources. One is an external "flush up to stage s" vector. The other is a built-in conservative fallback that empties the first `FLUSH_K` stages while stage `FLUSH_K` (counting from 0) holds an instruction. A selectable variant applies the fallback only to register-writing instructions. A stage whose instruction has already changed architected state is marked protected, and it is never flushed. When a flush discards real instructions, the block names the oldest discarded tag so that fetch can restart there. Every issued instruction therefore leaves the last stage once, in issue order.

Top module: `hazard_sequencer`

## Requirements
- R1: `stall[s]` is high exactly when some `stall_to[j]` with j >= s is high; a stall in a later stage freezes every earlier stage.
- R2: `bubble[s]` (s < STAGES-1) is high exactly when stage s stalls and stage s+1 does not; in the next cycle stage s+1 is empty.
- R3: A stage that is stalled and not flushed keeps its occupied bit, write bit and tag unchanged into the next cycle.
- R4: With `flush_mode` = 1, stages 0..FLUSH_K-1 are flushed in every cycle in which stage FLUSH_K is occupied (subject to R7).
- R5: With `flush_mode` = 2, the fallback of R4 fires only when the stage FLUSH_K instruction writes a register; with `flush_mode` 0 or 3 there is no automatic flush.
- R6: `flush_to[s]` flushes stage s and every stage below it.
- R7: An occupied stage with `protect` high is never flushed, nor is any stage above it by the same request; the flushed range ends just below the lowest protected occupied stage.
- R8: Flush beats stall: a stage that is both stalled and flushed is empty in the next cycle.
- R9: `pc_en` is high unless stage 0 is stalled or `refetch_vld` is high; stage 0 loads `fetch_vld`/`fetch_wr`/`fetch_tag` only when `pc_en` is high, and otherwise becomes empty unless it is stalled.
- R10: When a flush removes at least one occupied stage, `refetch_vld` is high and `refetch_tag` is the tag from the highest-numbered flushed occupied stage.
- R11: The last stage retires (`retire_vld`, `retire_tag`, `retire_wr`) when it is occupied, not stalled and not flushed. Restarting fetch at `refetch_tag` makes the retired tags run 0, 1, 2, ... without gaps or repeats, and retirement keeps advancing under the flush fallback.
- R12: After reset every stage is empty and nothing retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_mode | input | 2 | 0/3 no fallback, 1 fallback on any instruction, 2 fallback on register writers |
| stall_to | input | STAGES | Bit s requests a stall of stages 0..s |
| flush_to | input | STAGES | Bit s requests a flush of stages 0..s |
| protect | input | STAGES | Bit s: instruction in stage s already changed architected state |
| fetch_vld | input | 1 | Fetch offers an instruction |
| fetch_wr | input | 1 | Offered instruction writes a register |
| fetch_tag | input | TAG_W | Tag of offered instruction |
| pc_en | output | 1 | Fetch may advance; offered instruction accepted |
| stall | output | STAGES | Per-stage stall enable |
| flush | output | STAGES | Per-stage flush |
| bubble | output | STAGES-1 | Bit s: an empty slot enters stage s+1 |
| refetch_vld | output | 1 | Fetch must restart at refetch_tag |
| refetch_tag | output | TAG_W | Oldest discarded tag |
| stage_vld | output | STAGES | Occupied bit per stage |
| retire_vld | output | 1 | An instruction leaves the last stage |
| retire_wr | output | 1 | Retiring instruction writes a register |
| retire_tag | output | TAG_W | Tag of retiring instruction |

## Verification
The bench targets cycles where stall and flush meet on the same stage. A design that let the stall win would keep a discarded instruction, and that instruction would later retire twice. It also targets protected stages inside a flush range. A design that flushed past such a stage would replay an instruction that already took effect, and one that ignored the cut would skip instructions. The fallback is driven in all four modes while stage FLUSH_K is stalled and while it is not. A wrong trigger shows up as extra or missing flushes. A wrong restart tag breaks the gap-free retire sequence, and a fallback that never lets the trigger instruction move starves retirement.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FM_OFF  = 2'd0,
        FM_ANY  = 2'd1,
        FM_WR   = 2'd2,
        FM_RSVD = 2'd3
    } flush_mode_e;

endpackage

// File: rtl/hz_stall_chain.sv
module hz_stall_chain #(
    parameter int STAGES = 5
) (
    input  logic [STAGES-1:0] stall_to,
    output logic [STAGES-1:0] stall,
    output logic [STAGES-2:0] bubble
);

    always_comb begin
        stall[STAGES-1] = stall_to[STAGES-1];
        for (int s = STAGES - 2; s >= 0; s--) begin
            stall[s] = stall_to[s] | stall[s+1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES - 1; g++) begin : g_bub
            assign bubble[g] = stall[g] & ~stall[g+1];
        end
    endgenerate

endmodule

// File: rtl/hz_flush_ctl.sv
module hz_flush_ctl
    import hz_pkg::*;
#(
    parameter int STAGES  = 5,
    parameter int FLUSH_K = 2,
    parameter int TAG_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  flush_mode_e                   mode,
    input  logic [STAGES-1:0]             flush_to,
    input  logic [STAGES-1:0]             protect,
    input  logic [STAGES-1:0]             vld,
    input  logic [STAGES-1:0]             wr,
    input  logic [STAGES-1:0][TAG_W-1:0]  tag,
    output logic [STAGES-1:0]             flush,
    output logic                          refetch_vld,
    output logic [TAG_W-1:0]              refetch_tag
);

    localparam logic [STAGES-1:0] LOW_MASK = {STAGES{1'b1}} >> (STAGES - FLUSH_K);

    logic                auto_trig;
    logic [STAGES-1:0]   req;
    logic [STAGES-1:0]   reach;
    logic [STAGES-1:0]   guard;
    logic [STAGES-1:0]   cut;

    always_comb begin
        auto_trig = vld[FLUSH_K] &&
                    ((mode == FM_ANY) || ((mode == FM_WR) && wr[FLUSH_K]));
        req = flush_to;
        if (auto_trig) req[FLUSH_K-1] = 1'b1;

        reach[STAGES-1] = req[STAGES-1];
        for (int s = STAGES - 2; s >= 0; s--) begin
            reach[s] = req[s] | reach[s+1];
        end

        guard  = protect & vld;
        cut[0] = guard[0];
        for (int s = 1; s < STAGES; s++) begin
            cut[s] = cut[s-1] | guard[s];
        end

        flush = reach & ~cut;

        refetch_vld = 1'b0;
        refetch_tag = '0;
        for (int s = 0; s < STAGES; s++) begin
            if (flush[s] && vld[s]) begin
                refetch_vld = 1'b1;
                refetch_tag = tag[s];
            end
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_chk
            p_keep_protected_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (vld[g] && protect[g]) |-> !flush[g]);
        end
    endgenerate

    p_fallback_any_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == FM_ANY) && vld[FLUSH_K] && ((protect & vld & LOW_MASK) == '0))
        |-> ((flush & LOW_MASK) == LOW_MASK));

endmodule

// File: rtl/hz_stage_regs.sv
module hz_stage_regs #(
    parameter int STAGES = 5,
    parameter int TAG_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [STAGES-1:0]             stall,
    input  logic [STAGES-1:0]             flush,
    input  logic                          accept,
    input  logic                          fetch_vld,
    input  logic                          fetch_wr,
    input  logic [TAG_W-1:0]              fetch_tag,
    output logic [STAGES-1:0]             vld,
    output logic [STAGES-1:0]             wr,
    output logic [STAGES-1:0][TAG_W-1:0]  tag,
    output logic                          retire_vld,
    output logic                          retire_wr,
    output logic [TAG_W-1:0]              retire_tag
);

    typedef struct packed {
        logic [STAGES-1:0]            vld;
        logic [STAGES-1:0]            wr;
        logic [STAGES-1:0][TAG_W-1:0] tag;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        // stage 0 is fed by fetch
        if (stall[0]) begin
            if (flush[0]) pipe_d.vld[0] = 1'b0;
        end else begin
            pipe_d.vld[0] = accept & fetch_vld;
            pipe_d.wr[0]  = fetch_wr;
            pipe_d.tag[0] = fetch_tag;
        end
        for (int s = 1; s < STAGES; s++) begin
            if (stall[s]) begin
                if (flush[s]) pipe_d.vld[s] = 1'b0;
            end else begin
                pipe_d.vld[s] = pipe_q.vld[s-1] & ~flush[s-1] & ~stall[s-1];
                pipe_d.wr[s]  = pipe_q.wr[s-1];
                pipe_d.tag[s] = pipe_q.tag[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign vld        = pipe_q.vld;
    assign wr         = pipe_q.wr;
    assign tag        = pipe_q.tag;
    assign retire_vld = pipe_q.vld[STAGES-1] & ~stall[STAGES-1] & ~flush[STAGES-1];
    assign retire_wr  = pipe_q.wr[STAGES-1];
    assign retire_tag = pipe_q.tag[STAGES-1];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_chk
            p_hold_stalled_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (stall[g] && !flush[g]) |=>
                    (pipe_q.vld[g] == $past(pipe_q.vld[g]) &&
                     pipe_q.tag[g] == $past(pipe_q.tag[g]) &&
                     pipe_q.wr[g]  == $past(pipe_q.wr[g])));
            p_flush_beats_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (stall[g] && flush[g]) |=> !pipe_q.vld[g]);
        end
    endgenerate

endmodule

// File: rtl/hazard_sequencer.sv
module hazard_sequencer
    import hz_pkg::*;
#(
    parameter int STAGES  = 5,
    parameter int FLUSH_K = 2,
    parameter int TAG_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           flush_mode,
    input  logic [STAGES-1:0]    stall_to,
    input  logic [STAGES-1:0]    flush_to,
    input  logic [STAGES-1:0]    protect,
    input  logic                 fetch_vld,
    input  logic                 fetch_wr,
    input  logic [TAG_W-1:0]     fetch_tag,
    output logic                 pc_en,
    output logic [STAGES-1:0]    stall,
    output logic [STAGES-1:0]    flush,
    output logic [STAGES-2:0]    bubble,
    output logic                 refetch_vld,
    output logic [TAG_W-1:0]     refetch_tag,
    output logic [STAGES-1:0]    stage_vld,
    output logic                 retire_vld,
    output logic                 retire_wr,
    output logic [TAG_W-1:0]     retire_tag
);

    logic [STAGES-1:0]            occ_wr;
    logic [STAGES-1:0][TAG_W-1:0] occ_tag;

    hz_stall_chain #(.STAGES(STAGES)) u_stall (
        .stall_to (stall_to),
        .stall    (stall),
        .bubble   (bubble)
    );

    hz_flush_ctl #(.STAGES(STAGES), .FLUSH_K(FLUSH_K), .TAG_W(TAG_W)) u_flush (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (flush_mode_e'(flush_mode)),
        .flush_to    (flush_to),
        .protect     (protect),
        .vld         (stage_vld),
        .wr          (occ_wr),
        .tag         (occ_tag),
        .flush       (flush),
        .refetch_vld (refetch_vld),
        .refetch_tag (refetch_tag)
    );

    assign pc_en = ~stall[0] & ~refetch_vld;

    hz_stage_regs #(.STAGES(STAGES), .TAG_W(TAG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (stall),
        .flush      (flush),
        .accept     (pc_en),
        .fetch_vld  (fetch_vld),
        .fetch_wr   (fetch_wr),
        .fetch_tag  (fetch_tag),
        .vld        (stage_vld),
        .wr         (occ_wr),
        .tag        (occ_tag),
        .retire_vld (retire_vld),
        .retire_wr  (retire_wr),
        .retire_tag (retire_tag)
    );

    generate
        for (genvar g = 0; g < STAGES - 1; g++) begin : g_chk
            p_bubble_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
                bubble[g] |=> !stage_vld[g+1]);
        end
    endgenerate

    p_stage0_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall[0] && !flush[0]) |=> ($stable(stage_vld[0]) && !$past(pc_en)));

endmodule

// File: tb/sim_hazard_sequencer.sv
module sim_hazard_sequencer;

    localparam int N = 5;
    localparam int K = 2;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    flush_mode = 2'd0;
    logic [N-1:0]  stall_to = '0, flush_to = '0, protect = '0;
    logic          fetch_vld = 1'b0, fetch_wr = 1'b0;
    logic [TW-1:0] fetch_tag = '0;
    logic          pc_en, refetch_vld, retire_vld, retire_wr;
    logic [N-1:0]  stall, flush, stage_vld;
    logic [N-2:0]  bubble;
    logic [TW-1:0] refetch_tag, retire_tag;

    always #5 clk = ~clk;

    hazard_sequencer #(.STAGES(N), .FLUSH_K(K), .TAG_W(TW)) u0 (.*);

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    int m_vld[N], m_wr[N], m_tag[N];
    int next_tag = 0, exp_ret = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input int mode, input int stall_pct, input int flush_pct,
                        input int prot_pct, inout int retired);
        logic [N-1:0] e_stall, e_flush, e_bub_full;
        logic [N-2:0] e_bub;
        int limit, ref_idx, n_vld[N], n_wr[N], n_tag[N];
        bit trig, e_pc, e_ret;
        @(negedge clk);
        flush_mode = 2'(mode);
        for (int s = 0; s < N; s++) begin
            stall_to[s] = ($urandom_range(99) < stall_pct);
            flush_to[s] = ($urandom_range(99) < flush_pct);
            protect[s]  = ($urandom_range(99) < prot_pct);
        end
        fetch_vld = ($urandom_range(99) < 85);
        fetch_wr  = $urandom_range(1);
        fetch_tag = TW'(next_tag);
        #1;
        // R1: stall of s if any request at s or later
        for (int s = 0; s < N; s++) begin
            e_stall[s] = 1'b0;
            for (int j = s; j < N; j++) if (stall_to[j]) e_stall[s] = 1'b1;
        end
        for (int s = 0; s < N - 1; s++) e_bub[s] = e_stall[s] && !e_stall[s+1];
        e_bub_full = {1'b0, e_bub};
        // flush range
        limit = -1;
        for (int j = 0; j < N; j++) if (flush_to[j]) limit = j;
        trig = (m_vld[K] != 0) && (mode == 1 || (mode == 2 && m_wr[K] != 0));
        if (trig && limit < K - 1) limit = K - 1;
        for (int j = 0; j <= limit; j++) begin
            if (protect[j] && m_vld[j] != 0) begin
                limit = j - 1;
                break;
            end
        end
        for (int s = 0; s < N; s++) e_flush[s] = (s <= limit);
        ref_idx = -1;
        for (int j = limit; j >= 0; j--) if (m_vld[j] != 0) begin ref_idx = j; break; end
        e_pc  = !e_stall[0] && ref_idx < 0;
        e_ret = m_vld[N-1] != 0 && !e_stall[N-1] && !e_flush[N-1];

        chk(stall == e_stall, "R1", "stall", int'(stall), int'(e_stall));
        chk(bubble == e_bub, "R2", "bubble", int'(bubble), int'(e_bub));
        chk(flush == e_flush, (mode == 1) ? "R4 R6 R7" : "R5 R6 R7", "flush", int'(flush), int'(e_flush));
        chk(pc_en == e_pc, "R9", "pc_en", int'(pc_en), int'(e_pc));
        chk(refetch_vld == (ref_idx >= 0), "R10", "refetch_vld", int'(refetch_vld), int'(ref_idx >= 0));
        if (ref_idx >= 0)
            chk(refetch_tag == TW'(m_tag[ref_idx]), "R10", "refetch_tag", int'(refetch_tag), m_tag[ref_idx] % 256);
        chk(retire_vld == e_ret, "R11", "retire_vld", int'(retire_vld), int'(e_ret));
        if (e_ret) begin
            chk(retire_tag == TW'(exp_ret), "R11", "retire_tag order", int'(retire_tag), exp_ret % 256);
            chk(retire_wr == (m_wr[N-1] != 0), "R11", "retire_wr", int'(retire_wr), m_wr[N-1]);
            exp_ret++;
            retired++;
        end
        // next model state
        for (int s = 0; s < N; s++) begin
            n_vld[s] = m_vld[s]; n_wr[s] = m_wr[s]; n_tag[s] = m_tag[s];
            if (e_stall[s]) begin
                if (e_flush[s]) n_vld[s] = 0;
            end else if (s == 0) begin
                n_vld[0] = (e_pc && fetch_vld) ? 1 : 0;
                n_wr[0] = fetch_wr; n_tag[0] = next_tag;
            end else begin
                n_vld[s] = (m_vld[s-1] != 0 && !e_flush[s-1] && !e_stall[s-1]) ? 1 : 0;
                n_wr[s] = m_wr[s-1]; n_tag[s] = m_tag[s-1];
            end
        end
        if (ref_idx >= 0) next_tag = m_tag[ref_idx];
        else if (e_pc && fetch_vld) next_tag++;
        for (int s = 0; s < N; s++) begin
            m_vld[s] = n_vld[s]; m_wr[s] = n_wr[s]; m_tag[s] = n_tag[s];
        end
        // stage occupancy after the coming edge, checked on the next call
    endtask

    task automatic check_occ();
        logic [N-1:0] e_occ;
        for (int s = 0; s < N; s++) e_occ[s] = (m_vld[s] != 0);
        chk(stage_vld == e_occ, "R2 R3 R8", "stage_vld", int'(stage_vld), int'(e_occ));
    endtask

    initial begin
        for (int s = 0; s < N; s++) begin m_vld[s] = 0; m_wr[s] = 0; m_tag[s] = 0; end
        repeat (3) @(negedge clk);
        chk(stage_vld == '0, "R12", "reset stage_vld", int'(stage_vld), 0);
        chk(retire_vld == 1'b0, "R12", "reset retire", int'(retire_vld), 0);
        rst_n = 1'b1;
        for (int ph = 0; ph < 8; ph++) begin
            int retired = 0;
            for (int c = 0; c < 1500; c++) begin
                step(ph % 4, (ph < 4) ? 6 : 20, 3, 12, retired);
                @(posedge clk);
                #1;
                check_occ();
            end
            // R11: forward progress in every mode
            chk(retired > 10, "R11", "progress", retired, 11);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule